// File: doc/BRIEF.md
# Dual Sound Generator Bus Strober

This block sits on the write side of a sound processor and turns register writes into bus cycles for two programmable sound generator chips, each of which takes a byte on a shared bus together with a direction/mode pair. It also drives the three control lines of a speech chip. The processor first writes the byte it wants to send into a holding register. It then writes a control word. A transfer fires only when the strobe bit of the control word drops from one to zero between two consecutive control writes. The chip select and the address-or-data mode are taken from that same falling-edge control word.

The processor reaches the block through one write port. A select input picks either the holding register or the control register. Each transfer appears as a one-cycle write pulse on the strobe line of the chosen chip. The mode line and the byte bus are updated in that same cycle and keep their values until the next transfer. The speech lines follow the matching control bits as levels. A one-cycle load pulse marks a high-to-low step of the data-present bit. A fixed status byte is always available for the processor to read.

Top module: `sound_bus_strober`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, every output except `statusData` is 0.
- R2: A write with `wrSel`=0 loads the holding register. It changes no output in the following cycle.
- R3: A transfer happens only on a control write (`wrSel`=1) whose bit 2 is 0 when bit 2 of the previous control write was 1. The transfer is a pulse on one `psgStrobe` bit that lasts exactly the one cycle after the write edge.
- R4: Bit 3 of the transfer's control word selects the chip. A value of 1 pulses `psgStrobe[0]`; a value of 0 pulses `psgStrobe[1]`.
- R5: `psgAddrMode` takes bit 4 of the transfer's control word (1 = address write, 0 = data write). It changes only in a transfer cycle and holds between transfers.
- R6: `psgBus` takes the holding register's contents as they stood at the control write. It changes only in a transfer cycle.
- R7: After each control write, `speechReset`, `speechPresent` and `speechTest` follow bits 7, 6 and 5 of the word as levels, from the next cycle on.
- R8: `speechLoad` pulses for one cycle exactly when a control write takes bit 6 from 1 to 0, in the same cycle that `speechPresent` falls.
- R9: After reset the remembered strobe and present bits are 0. The first control write therefore starts neither a transfer nor a speech load.
- R10: `statusData` always reads 0xC0, meaning the speech data-request bit 7 and the test-switch bit 6 are high.
- R11: At most one bit of `psgStrobe` is high at any time, and no two transfer pulses fall in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write enable from the sound processor |
| wrSel | input | 1 | 0 = holding register, 1 = control register |
| wrData | input | 8 | Write data |
| statusData | output | 8 | Constant status byte |
| psgStrobe | output | 2 | One-cycle write pulse for each sound generator chip |
| psgAddrMode | output | 1 | 1 = address/register-select write, 0 = data write |
| psgBus | output | 8 | Byte presented to the sound generator chips |
| speechReset | output | 1 | Speech chip reset level |
| speechTest | output | 1 | Speech chip direct-data-test level |
| speechPresent | output | 1 | Speech chip data-present level |
| speechLoad | output | 1 | One-cycle pulse on data-present falling |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and the 0xC0 status value. This covers every control bit position and both chip selects. Directed sequences come first. They cover the first control write after reset, a strobe held high across two writes, a holding-register write placed between strobe writes, and a speech load. A long stretch of random writes follows. It mixes holding and control writes so that every combination of strobe, select, mode and present transitions is reached.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Control word bit positions; the strobe bit is the lowest one decoded.
  localparam int STB_BIT     = 2;
  localparam int SEL_BIT     = 3;
  localparam int MODE_BIT    = 4;
  localparam int TEST_BIT    = 5;
  localparam int PRESENT_BIT = 6;
  localparam int RESET_BIT   = 7;

  localparam int NUM_CHIPS   = 2;

  // Strobes passed from control to datapath in the cycle of a write.
  typedef struct packed {
    logic latchWr;     // holding register load
    logic ctrlWr;      // control register write
    logic xferGo;      // falling strobe seen: launch a chip transfer
    logic chipIdx;     // index of the chip to pulse
    logic addrMode;    // 1 = address cycle, 0 = data cycle
    logic speechLoad;  // falling present bit seen
    logic spReset;
    logic spTest;
    logic spPresent;
  } ctrlStrobes_t;

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    wrSel,
  input  logic [DATA_W-1:STB_BIT] ctrlBits,
  output ctrlStrobes_t            stb
);

  logic prevStrobe;
  logic prevPresent;
  logic ctrlWr;

  assign ctrlWr = wrEn && wrSel;

  // Only the two edge-sensitive bits of the last control word are remembered.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStrobe  <= 1'b0;
      prevPresent <= 1'b0;
    end else if (ctrlWr) begin
      prevStrobe  <= ctrlBits[STB_BIT];
      prevPresent <= ctrlBits[PRESENT_BIT];
    end
  end

  always_comb begin
    stb            = '0;
    stb.latchWr    = wrEn && !wrSel;
    stb.ctrlWr     = ctrlWr;
    stb.xferGo     = ctrlWr && prevStrobe && !ctrlBits[STB_BIT];
    stb.chipIdx    = ctrlBits[SEL_BIT] ? 1'b0 : 1'b1;
    stb.addrMode   = ctrlBits[MODE_BIT];
    stb.speechLoad = ctrlWr && prevPresent && !ctrlBits[PRESENT_BIT];
    stb.spReset    = ctrlBits[RESET_BIT];
    stb.spTest     = ctrlBits[TEST_BIT];
    stb.spPresent  = ctrlBits[PRESENT_BIT];
  end

  // R9
  first_ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !stb.xferGo && !stb.speechLoad);

endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         stb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [NUM_CHIPS-1:0] psgStrobe,
  output logic                 psgAddrMode,
  output logic [DATA_W-1:0]    psgBus,
  output logic                 speechReset,
  output logic                 speechTest,
  output logic                 speechPresent,
  output logic                 speechLoad
);

  logic [DATA_W-1:0] latchQ;

  always_ff @(posedge clk) begin
    if (!rstN) latchQ <= '0;
    else if (stb.latchWr) latchQ <= wrData;
  end

  // One pulse register per chip.
  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    always_ff @(posedge clk) begin
      if (!rstN) psgStrobe[c] <= 1'b0;
      else       psgStrobe[c] <= stb.xferGo && (stb.chipIdx == c[0]);
    end
  end

  // Mode and bus change only with a transfer and hold between transfers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      psgAddrMode <= 1'b0;
      psgBus      <= '0;
    end else if (stb.xferGo) begin
      psgAddrMode <= stb.addrMode;
      psgBus      <= latchQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      speechReset   <= 1'b0;
      speechTest    <= 1'b0;
      speechPresent <= 1'b0;
      speechLoad    <= 1'b0;
    end else begin
      speechLoad <= stb.speechLoad;
      if (stb.ctrlWr) begin
        speechReset   <= stb.spReset;
        speechTest    <= stb.spTest;
        speechPresent <= stb.spPresent;
      end
    end
  end

  // R11
  psg_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(psgStrobe));

  // R3
  psg_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psgStrobe != '0) |=> (psgStrobe == '0));

  // R5
  psg_mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psgStrobe == '0) |-> $stable(psgAddrMode) && $stable(psgBus));

  // R8
  speech_load_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    speechLoad |-> $fell(speechPresent));

  // R8
  speech_fall_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(speechPresent) |-> speechLoad);

endmodule

// File: rtl/sound_bus_strober.sv
module sound_bus_strober
  import sbs_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter logic [DATA_W-1:0] STATUS_VALUE = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    statusData,
  output logic [NUM_CHIPS-1:0] psgStrobe,
  output logic                 psgAddrMode,
  output logic [DATA_W-1:0]    psgBus,
  output logic                 speechReset,
  output logic                 speechTest,
  output logic                 speechPresent,
  output logic                 speechLoad
);

  ctrlStrobes_t stb;

  assign statusData = STATUS_VALUE;

  sbs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .ctrlBits (wrData[DATA_W-1:STB_BIT]),
    .stb      (stb)
  );

  sbs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .wrData        (wrData),
    .psgStrobe     (psgStrobe),
    .psgAddrMode   (psgAddrMode),
    .psgBus        (psgBus),
    .speechReset   (speechReset),
    .speechTest    (speechTest),
    .speechPresent (speechPresent),
    .speechLoad    (speechLoad)
  );

  // R7
  speech_reset_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(speechReset) |-> $past(wrEn && wrSel && wrData[RESET_BIT]));

  // R2
  latch_no_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (psgStrobe == '0) && !speechLoad);

endmodule

// File: tb/sound_bus_strober_tb.sv
module sound_bus_strober_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] statusData;
  logic [1:0] psgStrobe;
  logic       psgAddrMode;
  logic [7:0] psgBus;
  logic       speechReset, speechTest, speechPresent, speechLoad;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // Behavioural reference state.
  int expStrobe = 0, expMode = 0, expBus = 0;
  int expRst = 0, expTst = 0, expPres = 0, expLoad = 0;
  int mLatch = 0, mPrevStb = 0, mPrevPres = 0;
  bit inReset = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sound_bus_strober u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .statusData(statusData), .psgStrobe(psgStrobe), .psgAddrMode(psgAddrMode),
    .psgBus(psgBus), .speechReset(speechReset), .speechTest(speechTest),
    .speechPresent(speechPresent), .speechLoad(speechLoad)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, updated on every rising edge.
  always @(posedge clk) begin
    inReset = !rstN;
    if (!rstN) begin
      expStrobe = 0; expMode = 0; expBus = 0; expRst = 0; expTst = 0;
      expPres = 0; expLoad = 0; mLatch = 0; mPrevStb = 0; mPrevPres = 0;
    end else begin
      expStrobe = 0;
      expLoad = 0;
      if (wrEn && !wrSel) mLatch = wrData;
      if (wrEn && wrSel) begin
        if (mPrevStb == 1 && wrData[2] == 0) begin
          expStrobe = wrData[3] ? 1 : 2;
          expMode = wrData[4];
          expBus = mLatch;
        end
        if (mPrevPres == 1 && wrData[6] == 0) expLoad = 1;
        expRst = wrData[7]; expPres = wrData[6]; expTst = wrData[5];
        mPrevStb = wrData[2]; mPrevPres = wrData[6];
      end
    end
  end

  // Compare every cycle, a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      if (inReset) begin
        chk("R1 strobe", psgStrobe, 0);
        chk("R1 bus", psgBus, 0);
        chk("R1 speech", {speechReset, speechTest, speechPresent, speechLoad}, 0);
      end else begin
        chk("R3/R4 strobe", psgStrobe, expStrobe);
        chk("R5 mode", psgAddrMode, expMode);
        chk("R6 bus", psgBus, expBus);
        chk("R7 reset", speechReset, expRst);
        chk("R7 present", speechPresent, expPres);
        chk("R7 test", speechTest, expTst);
        chk("R8 load", speechLoad, expLoad);
      end
      chk("R10 status", statusData, 8'hC0);
      chk("R11 onehot", $countones(psgStrobe) <= 1, 1);
    end
  end

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mode", psgAddrMode, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 first cycle", {psgStrobe, speechLoad}, 0);

    wr(0, 8'hA5);
    chk("R2 latch write no strobe", psgStrobe, 0);
    chk("R2 latch write bus", psgBus, 0);

    wr(1, 8'h40);                     // first control write: nothing fires
    chk("R9 first write no xfer", psgStrobe, 0);
    chk("R9 first write no load", speechLoad, 0);

    wr(1, 8'h04);                     // strobe high, present falls
    chk("R8 present fall load", speechLoad, 1);
    wr(1, 8'h18);                     // strobe falls, chip0, address
    chk("R4 chip0 select", psgStrobe, 2'b01);
    chk("R5 address mode", psgAddrMode, 1);
    chk("R6 bus value", psgBus, 8'hA5);
    @(negedge clk);
    chk("R3 one-cycle pulse", psgStrobe, 0);

    wr(0, 8'h3C);
    wr(1, 8'h0C);                     // strobe high again
    chk("R3 rising no xfer", psgStrobe, 0);
    wr(1, 8'h04);                     // stays high: no transfer
    chk("R3 held high no xfer", psgStrobe, 0);
    wr(0, 8'h77);                     // latch write between strobe writes
    chk("R2 latch between", psgStrobe, 0);
    wr(1, 8'h00);                     // fall: chip1, data
    chk("R4 chip1 select", psgStrobe, 2'b10);
    chk("R5 data mode", psgAddrMode, 0);
    chk("R6 latest latch", psgBus, 8'h77);

    wr(1, 8'hE0);
    chk("R7 speech levels", {speechReset, speechPresent, speechTest}, 3'b111);
    wr(1, 8'h80);
    chk("R8 load pulse", speechLoad, 1);
    @(negedge clk);
    chk("R8 load one cycle", speechLoad, 0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wrEn = ($urandom % 4) != 0;
      wrSel = $urandom % 2;
      wrData = $urandom;
    end
    @(negedge clk);
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule